// File: doc/BRIEF.md
# Consecutive Bus Error Supervisor

This block watches the bus errors seen by an autonomous DMA engine and decides when to give up. Software programs a retry budget and an enable for automatic error handling through one 8-bit register. While the autonomous mode runs, each bus error uses up one unit of the budget, and each successful transaction refills it. An error that arrives once the budget is used up raises an error event and a one-cycle stop request that tells the mode controller to leave autonomous operation.

Below exhaustion, every bus error that automatic handling covers produces a one-cycle retry request to the FIFO logic. On the receive side this is a flush, so the packet can arrive again. On the transmit side in non-isochronous operation it is a reload, so the packet can be rescheduled. Isochronous transmit errors are not retried. The block never does the flush or reload itself.

The preset and the live counter share the register address. While the mode is active, writes are locked out and a read shows the live counter. While the mode is inactive, a read shows the preset, and the live counter follows the preset. That same tracking loads the counter on the cycle the mode starts and reloads it when the mode stops. All control pins are plain level or strobe signals, with no valid/ready handshake, because no data stream passes through the block.

Top module: `bus_err_supervisor`

## Requirements
- R1: After reset, the register reads 8'h00 and err_event, stop_req, fifo_flush and fifo_reload are all 0.
- R2: While auto_active is 0, a write with reg_wr=1 stores reg_wdata[6:0] as the preset and reg_wdata[7] as the handling enable. From then on, reg_rdata returns {enable, preset}.
- R3: A write while auto_active is 1 changes neither the preset nor the enable. This is visible in reg_rdata both during and after the active period.
- R4: While auto_active is 1, reg_rdata returns {enable, live counter}. The live counter equals the preset on the first active cycle.
- R5: While active with the enable set, a bus_err without xfer_ok on a nonzero counter lowers the counter by exactly one, one clock later.
- R6: With the enable clear, bus_err changes neither the counter nor any request output, even when the counter is zero.
- R7: While active, xfer_ok reloads the counter from the preset one clock later, and it wins over a bus_err in the same cycle.
- R8: When auto_active falls, the counter returns to the preset.
- R9: A handled bus_err on a zero counter pulses err_event and stop_req high together for one cycle, one clock later. The counter stays at 0.
- R10: A handled bus_err on a nonzero counter in non-isochronous mode (isoc=0) pulses, one clock later, fifo_flush if dir_rx=1 or fifo_reload if dir_rx=0.
- R11: In isochronous mode (isoc=1), a handled receive error still pulses fifo_flush, while a handled transmit error pulses neither retry output. Both still count down the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: bit 7 enable, bits 6:0 preset |
| reg_rdata | output | 8 | Read data: enable and preset or live count |
| auto_active | input | 1 | Autonomous DMA mode running |
| isoc | input | 1 | Current endpoint is isochronous |
| dir_rx | input | 1 | 1 for receive, 0 for transmit |
| bus_err | input | 1 | Bus error on a transfer, one-cycle strobe |
| xfer_ok | input | 1 | Successful transaction, one-cycle strobe |
| err_event | output | 1 | Error budget exhausted, one-cycle pulse |
| stop_req | output | 1 | Request to end autonomous mode, one-cycle pulse |
| fifo_flush | output | 1 | Request to flush the receive FIFO |
| fifo_reload | output | 1 | Request to reload and reschedule the transmit FIFO |

## Verification
Counter changes and all four request pulses are registered, so each shows up one clock after the strobe that caused it. The read value moves with auto_active in the same cycle, because the read mux is combinational. Each scenario task drives its inputs on a falling edge and checks on the next falling edge, one rising edge later. That is when both the updated counter and any pulse are visible. Mode changes are checked right after auto_active is driven, and again once the following edge has reloaded the counter.

// File: rtl/bes_pkg.sv
package bes_pkg;
  typedef enum logic [1:0] {
    RETRY_NONE   = 2'd0,
    RETRY_FLUSH  = 2'd1,
    RETRY_RELOAD = 2'd2
  } retry_e;

  function automatic retry_e pick_retry(input logic rx, input logic iso);
    if (rx)       return RETRY_FLUSH;
    else if (!iso) return RETRY_RELOAD;
    else          return RETRY_NONE;
  endfunction
endpackage

// File: rtl/bes_regs.sv
module bes_regs #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wr,
  input  logic [CNT_W:0]   wdata,
  output logic [CNT_W-1:0] preset_q,
  output logic [CNT_W-1:0] preset_d,
  output logic             aeh_q
);
  logic accept;
  logic aeh_d;

  assign accept = wr && !active;

  always_comb begin
    preset_d = preset_q;
    aeh_d    = aeh_q;
    if (accept) begin
      preset_d = wdata[CNT_W-1:0];
      aeh_d    = wdata[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      aeh_q    <= 1'b0;
    end else begin
      preset_q <= preset_d;
      aeh_q    <= aeh_d;
    end
  end

  p_wr_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(preset_q) && $stable(aeh_q)));
endmodule

// File: rtl/bes_counter.sv
module bes_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             aeh,
  input  logic             bus_err,
  input  logic             xfer_ok,
  input  logic [CNT_W-1:0] preset_q,
  input  logic [CNT_W-1:0] preset_d,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_d;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!active)
      cnt_d = preset_d;
    else if (xfer_ok)
      cnt_d = preset_q;
    else if (bus_err && aeh && !cnt_zero)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && aeh && bus_err && !xfer_ok && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_aeh_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !aeh && !xfer_ok) |=> $stable(cnt_q));
  p_reload_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xfer_ok) |=> (cnt_q == preset_q));
  p_track_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == preset_q));
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_zero && !xfer_ok) |=> (cnt_q == '0));
endmodule

// File: rtl/bes_events.sv
module bes_events
  import bes_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic aeh,
  input  logic bus_err,
  input  logic xfer_ok,
  input  logic cnt_zero,
  input  logic isoc,
  input  logic dir_rx,
  output logic err_event,
  output logic stop_req,
  output logic fifo_flush,
  output logic fifo_reload
);
  logic   handled;
  logic   exhausted;
  retry_e action;

  assign handled   = active && aeh && bus_err && !xfer_ok;
  assign exhausted = handled && cnt_zero;
  assign action    = (handled && !cnt_zero) ? pick_retry(dir_rx, isoc) : RETRY_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_event   <= 1'b0;
      stop_req    <= 1'b0;
      fifo_flush  <= 1'b0;
      fifo_reload <= 1'b0;
    end else begin
      err_event   <= exhausted;
      stop_req    <= exhausted;
      fifo_flush  <= (action == RETRY_FLUSH);
      fifo_reload <= (action == RETRY_RELOAD);
    end
  end

  p_evt_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && aeh && bus_err && !xfer_ok && cnt_zero) |=> (err_event && stop_req));
  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !aeh |=> !(err_event || fifo_flush || fifo_reload));
  p_iso_tx_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (isoc && !dir_rx) |=> !fifo_reload);
endmodule

// File: rtl/bus_err_supervisor.sv
module bus_err_supervisor #(
  parameter int CNT_W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [7:0]   reg_wdata,
  output logic [7:0]   reg_rdata,
  input  logic         auto_active,
  input  logic         isoc,
  input  logic         dir_rx,
  input  logic         bus_err,
  input  logic         xfer_ok,
  output logic         err_event,
  output logic         stop_req,
  output logic         fifo_flush,
  output logic         fifo_reload
);
  localparam int REG_W = CNT_W + 1;

  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] preset_d;
  logic [CNT_W-1:0] cnt_q;
  logic             aeh_q;
  logic             cnt_zero;
  logic [REG_W-1:0] rd_full;

  bes_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .active(auto_active), .wr(reg_wr),
    .wdata(reg_wdata[REG_W-1:0]), .preset_q(preset_q), .preset_d(preset_d),
    .aeh_q(aeh_q)
  );

  bes_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(auto_active), .aeh(aeh_q),
    .bus_err(bus_err), .xfer_ok(xfer_ok), .preset_q(preset_q),
    .preset_d(preset_d), .cnt_q(cnt_q), .cnt_zero(cnt_zero)
  );

  bes_events u_evt (
    .clk(clk), .rst_n(rst_n), .active(auto_active), .aeh(aeh_q),
    .bus_err(bus_err), .xfer_ok(xfer_ok), .cnt_zero(cnt_zero),
    .isoc(isoc), .dir_rx(dir_rx), .err_event(err_event),
    .stop_req(stop_req), .fifo_flush(fifo_flush), .fifo_reload(fifo_reload)
  );

  assign rd_full   = {aeh_q, (auto_active ? cnt_q : preset_q)};
  assign reg_rdata = rd_full;

  p_first_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_active) |-> (cnt_q == preset_q));
endmodule

// File: tb/bus_err_supervisor_tb_top.sv
module bus_err_supervisor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic auto_active = 1'b0, isoc = 1'b0, dir_rx = 1'b1;
  logic bus_err = 1'b0, xfer_ok = 1'b0;
  logic err_event, stop_req, fifo_flush, fifo_reload;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bus_err_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .auto_active(auto_active), .isoc(isoc),
    .dir_rx(dir_rx), .bus_err(bus_err), .xfer_ok(xfer_ok),
    .err_event(err_event), .stop_req(stop_req), .fifo_flush(fifo_flush),
    .fifo_reload(fifo_reload)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [3:0] exp);
    chk(req, {28'd0, err_event, stop_req, fifo_flush, fifo_reload}, {28'd0, exp});
  endtask

  task automatic write_reg(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe(input logic e, input logic o);
    bus_err = e; xfer_ok = o;
    @(negedge clk);
    bus_err = 1'b0; xfer_ok = 1'b0;
  endtask

  task automatic set_mode(input logic a);
    auto_active = a;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 8'h00);
    chk_out("R1 outputs", 4'b0000);
  endtask

  task automatic t_write_read;
    write_reg(8'h83);
    chk("R2 read preset", reg_rdata, 8'h83);
    write_reg(8'h05);
    chk("R2 rewrite", reg_rdata, 8'h05);
    write_reg(8'h83);
  endtask

  task automatic t_lock;
    set_mode(1'b1);
    chk("R4 live on first active", reg_rdata, 8'h83);
    @(negedge clk);
    write_reg(8'h05);
    chk("R3 write ignored active", reg_rdata, 8'h83);
    set_mode(1'b0);
    @(negedge clk);
    chk("R3 preset kept", reg_rdata, 8'h83);
  endtask

  task automatic t_countdown;
    isoc = 1'b0; dir_rx = 1'b1;
    set_mode(1'b1);
    @(negedge clk);
    strobe(1'b1, 1'b0);
    chk("R5 dec 3->2", reg_rdata, 8'h82);
    chk_out("R10 rx flush", 4'b0010);
    strobe(1'b1, 1'b0);
    chk("R5 dec 2->1", reg_rdata, 8'h81);
    dir_rx = 1'b0;
    strobe(1'b1, 1'b0);
    chk("R5 dec 1->0", reg_rdata, 8'h80);
    chk_out("R10 tx reload", 4'b0001);
    strobe(1'b1, 1'b0);
    chk_out("R9 event and stop", 4'b1100);
    chk("R9 stays zero", reg_rdata, 8'h80);
    @(negedge clk);
    chk_out("R9 single pulse", 4'b0000);
    set_mode(1'b0);
    chk("R8 idle reads preset", reg_rdata, 8'h83);
    @(negedge clk);
    set_mode(1'b1);
    chk("R8 counter reloaded", reg_rdata, 8'h83);
    @(negedge clk);
    set_mode(1'b0);
  endtask

  task automatic t_success;
    dir_rx = 1'b1;
    set_mode(1'b1);
    @(negedge clk);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0);
    chk("R5 two errors", reg_rdata, 8'h81);
    strobe(1'b0, 1'b1);
    chk("R7 reload on ok", reg_rdata, 8'h83);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b1);
    chk("R7 ok wins over err", reg_rdata, 8'h83);
    chk_out("R7 no retry when ok", 4'b0000);
    set_mode(1'b0);
    @(negedge clk);
  endtask

  task automatic t_aeh_off;
    write_reg(8'h02);
    set_mode(1'b1);
    @(negedge clk);
    strobe(1'b1, 1'b0);
    chk("R6 no dec", reg_rdata, 8'h02);
    chk_out("R6 no requests", 4'b0000);
    set_mode(1'b0);
    write_reg(8'h00);
    set_mode(1'b1);
    @(negedge clk);
    strobe(1'b1, 1'b0);
    chk_out("R6 zero no event", 4'b0000);
    set_mode(1'b0);
    @(negedge clk);
  endtask

  task automatic t_iso;
    write_reg(8'h82);
    isoc = 1'b1; dir_rx = 1'b1;
    set_mode(1'b1);
    @(negedge clk);
    strobe(1'b1, 1'b0);
    chk_out("R11 iso rx flush", 4'b0010);
    chk("R11 iso rx count", reg_rdata, 8'h81);
    dir_rx = 1'b0;
    strobe(1'b1, 1'b0);
    chk_out("R11 iso tx no retry", 4'b0000);
    chk("R11 iso tx count", reg_rdata, 8'h80);
    set_mode(1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_lock();
    t_countdown();
    t_success();
    t_aeh_off();
    t_iso();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule